// File: doc/BRIEF.md
# Prefixed 8-bit Opcode Decoder

This block turns a stream of single-byte opcodes from an 8-bit processor into a decoded record. Each byte arrives with a valid strobe. The block cuts the byte into fixed bit fields and classifies it through small lookup tables for registers, register pairs, branch conditions and arithmetic functions. The record names the operation class, the destination and source operands, the branch condition, and how many immediate bytes follow the opcode in the instruction stream.

One byte value (0xCB by default) is a prefix. It produces no result of its own. Instead, it marks the next accepted byte as belonging to a second opcode table. This block does not decode that second table in detail. It only reports that the byte was prefixed and passes the raw byte on. Opcodes that the main table does not cover are flagged as illegal and are never mistaken for a no-op.

The result is registered and appears together with a one-cycle done pulse. A fetch unit feeds the opcodes and an execute stage consumes the results. Neither is part of this block.

Top module: `opdec8_core`

## Requirements
- R1: Synchronous active-high reset clears every output to 0 and drops any pending prefix, so the first byte after reset is decoded through the main table.
- R2: An accepted byte (`op_valid`=1) that is not a swallowed prefix raises `dec_done` for exactly one cycle, in the cycle after the strobe. In that cycle `dec_raw` equals the byte. The outputs hold their values while no byte is accepted. Strobes may arrive on consecutive cycles.
- R3: The byte is split into x=bits 7:6, y=bits 5:3, z=bits 2:0, p=y>>1 and q=y[0]. When x=0 and z=0: y=0 gives NOP (class 0). y=1 gives LD16 (class 2) with dst mem-at-imm16 (21), src SP (12) and imm 2. y=2 gives STOP (class 3). y=3..7 gives JR (class 4) with src signed imm8 (16) and imm 1.
- R4: Condition codes are 0=not-zero, 1=zero, 2=not-carry, 3=carry and 4=always. A conditional JR uses y-4 and a conditional return uses y. Every other result carries 4.
- R5: Pair selectors are BC=9, DE=10, HL=11, SP=12, indexed by p. With x=0, z=1: q=0 gives LD16 (class 2) with dst the pair, src imm16 (15) and imm 2; q=1 gives ADD16 (class 5) with dst HL and src the pair. With x=0, z=3: q=0 gives INC16 (class 8) and q=1 gives DEC16 (class 9), with dst the pair.
- R6: With x=0 and z=2, p selects the memory operand mem-BC (17), mem-DE (18), mem-HL-then-increment (19) or mem-HL-then-decrement (20). The class is LD8 (class 1). q=0 has dst the memory operand and src A (8). q=1 has dst A and src the memory operand.
- R7: The register selector r[i] is i+1. This gives B=1, C=2, D=3, E=4, H=5, L=6, mem-HL=7 and A=8. With x=0: z=4 gives INC8 (class 6) with dst r[y]. z=5 gives DEC8 (class 7) with dst r[y]. z=6 gives LD8 with dst r[y], src imm8 (14) and imm 1. z=7 gives class 10+y, the single-byte accumulator and flag operations.
- R8: Byte 0x76 gives HALT (class 18) with no operands. Every other x=1 byte gives LD8 with dst r[y] and src r[z].
- R9: With x=2, the class is 19+y. In order the classes are ADD, ADC, SUB, SBC, AND, XOR, OR and CP. dst is A and src is r[z].
- R10: With x=3 and z=0: y=0..3 gives RET (class 27) with condition y. y=4 gives LD8 with dst high-page memory (22), src A and imm 1. y=5 gives ADDSP (class 28) with dst SP, src signed imm8 and imm 1.
- R11: `dec_imm_len` is 0, 1 or 2, as stated per case above. It is 0 for every other result.
- R12: When no prefix is pending, the prefix byte is swallowed. It gives no done pulse and arms the prefix. The next accepted byte, even after idle cycles and even if it is the prefix value again, gives class PREFIXED (29) with `dec_prefixed`=1. It has no operands, condition 4 and imm 0, and it clears the prefix.
- R13: Every byte not listed above (x=3 with z≠0 or with y=6,7) gives class ILLEGAL (30) with `dec_illegal`=1, no operands (0), condition 4 and imm 0. Legal and prefixed results have `dec_illegal`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Strobe: `op_byte` holds an opcode byte this cycle |
| op_byte | input | 8 | Opcode byte |
| dec_done | output | 1 | One-cycle pulse: a new decoded record is on the outputs |
| dec_class | output | 5 | Operation class code |
| dec_dst | output | 5 | Destination operand selector |
| dec_src | output | 5 | Source operand selector |
| dec_cond | output | 3 | Condition code |
| dec_imm_len | output | 2 | Number of immediate bytes that follow |
| dec_prefixed | output | 1 | Byte was decoded as a prefixed opcode |
| dec_illegal | output | 1 | Byte is not a legal main-table opcode |
| dec_raw | output | 8 | Raw byte of the current record |

## Verification
The bench targets the prefix state, because that is where a mistake is easiest to make. It sends a prefix followed by idle cycles, two prefixes in a row, and a prefix cut off by reset. A tracker that cleared too early would decode the second byte through the main table. A tracker that never cleared would mark every later byte as prefixed. Byte 0x76 is checked next to its load neighbours: if the override were missing, HALT would come out as a memory-to-memory load. Uncovered bytes such as 0xF0 and 0xFF must come out as illegal, never as NOP. Strobes on consecutive cycles show whether a record can be dropped or repeated.

// File: rtl/opdec8_pkg.sv
package opdec8_pkg;

  typedef enum logic [4:0] {
    CL_NOP      = 5'd0,
    CL_LD8      = 5'd1,
    CL_LD16     = 5'd2,
    CL_STOP     = 5'd3,
    CL_JR       = 5'd4,
    CL_ADD16    = 5'd5,
    CL_INC8     = 5'd6,
    CL_DEC8     = 5'd7,
    CL_INC16    = 5'd8,
    CL_DEC16    = 5'd9,
    CL_RLCA     = 5'd10,
    CL_RRCA     = 5'd11,
    CL_RLA      = 5'd12,
    CL_RRA      = 5'd13,
    CL_DAA      = 5'd14,
    CL_CPL      = 5'd15,
    CL_SCF      = 5'd16,
    CL_CCF      = 5'd17,
    CL_HALT     = 5'd18,
    CL_ADD      = 5'd19,
    CL_ADC      = 5'd20,
    CL_SUB      = 5'd21,
    CL_SBC      = 5'd22,
    CL_AND      = 5'd23,
    CL_XOR      = 5'd24,
    CL_OR       = 5'd25,
    CL_CP       = 5'd26,
    CL_RET      = 5'd27,
    CL_ADDSP    = 5'd28,
    CL_PREFIXED = 5'd29,
    CL_ILLEGAL  = 5'd30
  } dec_class_e;

  typedef enum logic [4:0] {
    OP_NONE    = 5'd0,
    OP_B       = 5'd1,
    OP_C       = 5'd2,
    OP_D       = 5'd3,
    OP_E       = 5'd4,
    OP_H       = 5'd5,
    OP_L       = 5'd6,
    OP_MHL     = 5'd7,
    OP_A       = 5'd8,
    OP_BC      = 5'd9,
    OP_DE      = 5'd10,
    OP_HL      = 5'd11,
    OP_SP      = 5'd12,
    OP_AF      = 5'd13,
    OP_IMM8    = 5'd14,
    OP_IMM16   = 5'd15,
    OP_SIMM8   = 5'd16,
    OP_MBC     = 5'd17,
    OP_MDE     = 5'd18,
    OP_MHLI    = 5'd19,
    OP_MHLD    = 5'd20,
    OP_MA16    = 5'd21,
    OP_MHIGH8  = 5'd22
  } opnd_e;

  typedef enum logic [2:0] {
    CC_NZ  = 3'd0,
    CC_Z   = 3'd1,
    CC_NC  = 3'd2,
    CC_C   = 3'd3,
    CC_ALW = 3'd4
  } cond_e;

  typedef struct packed {
    dec_class_e cls;
    opnd_e      dst;
    opnd_e      src;
    cond_e      cc;
    logic [1:0] imm;
    logic       ill;
  } dec_rec_t;

  // 8-bit register table: index i maps to code i+1 (B..L, mem-HL, A)
  function automatic opnd_e reg8_sel(input logic [2:0] idx);
    return opnd_e'(5'd1 + {2'b00, idx});
  endfunction

  // 16-bit pair table used by loads, inc/dec and 16-bit add
  function automatic opnd_e pair_sel(input logic [1:0] idx);
    return opnd_e'(5'd9 + {3'b000, idx});
  endfunction

  // indirect memory operand used by accumulator loads and stores
  function automatic opnd_e mem_sel(input logic [1:0] idx);
    return opnd_e'(5'd17 + {3'b000, idx});
  endfunction

  function automatic dec_rec_t mk_rec(input dec_class_e c, input opnd_e d,
                                      input opnd_e s, input cond_e cc,
                                      input logic [1:0] n);
    dec_rec_t r;
    r.cls = c;
    r.dst = d;
    r.src = s;
    r.cc  = cc;
    r.imm = n;
    r.ill = 1'b0;
    return r;
  endfunction

  localparam dec_rec_t ILLEGAL_REC = '{cls: CL_ILLEGAL, dst: OP_NONE, src: OP_NONE,
                                       cc: CC_ALW, imm: 2'd0, ill: 1'b1};

endpackage

// File: rtl/opdec8_fields.sv
module opdec8_fields #(
  parameter int OPW = 8
) (
  input  logic [OPW-1:0] op,
  output logic [1:0]     fx,
  output logic [2:0]     fy,
  output logic [2:0]     fz,
  output logic [1:0]     fp,
  output logic           fq
);
  localparam int X_LSB = OPW - 2;
  localparam int Y_LSB = X_LSB - 3;

  assign fx = op[X_LSB +: 2];
  assign fy = op[Y_LSB +: 3];
  assign fz = op[2:0];
  assign fp = fy[2:1];
  assign fq = fy[0];
endmodule

// File: rtl/opdec8_main_table.sv
module opdec8_main_table
  import opdec8_pkg::*;
(
  input  logic [1:0] fx,
  input  logic [2:0] fy,
  input  logic [2:0] fz,
  input  logic [1:0] fp,
  input  logic       fq,
  output dec_rec_t   rec
);
  always_comb begin
    rec = ILLEGAL_REC;
    case (fx)
      2'd0: begin
        case (fz)
          3'd0: begin
            case (fy)
              3'd0:    rec = mk_rec(CL_NOP,  OP_NONE, OP_NONE, CC_ALW, 2'd0);
              3'd1:    rec = mk_rec(CL_LD16, OP_MA16, OP_SP,   CC_ALW, 2'd2);
              3'd2:    rec = mk_rec(CL_STOP, OP_NONE, OP_NONE, CC_ALW, 2'd0);
              3'd3:    rec = mk_rec(CL_JR,   OP_NONE, OP_SIMM8, CC_ALW, 2'd1);
              default: rec = mk_rec(CL_JR,   OP_NONE, OP_SIMM8,
                                    cond_e'({1'b0, fy[1:0]}), 2'd1);
            endcase
          end
          3'd1: begin
            if (!fq) rec = mk_rec(CL_LD16,  pair_sel(fp), OP_IMM16, CC_ALW, 2'd2);
            else     rec = mk_rec(CL_ADD16, OP_HL, pair_sel(fp), CC_ALW, 2'd0);
          end
          3'd2: begin
            if (!fq) rec = mk_rec(CL_LD8, mem_sel(fp), OP_A, CC_ALW, 2'd0);
            else     rec = mk_rec(CL_LD8, OP_A, mem_sel(fp), CC_ALW, 2'd0);
          end
          3'd3: begin
            if (!fq) rec = mk_rec(CL_INC16, pair_sel(fp), OP_NONE, CC_ALW, 2'd0);
            else     rec = mk_rec(CL_DEC16, pair_sel(fp), OP_NONE, CC_ALW, 2'd0);
          end
          3'd4: rec = mk_rec(CL_INC8, reg8_sel(fy), OP_NONE, CC_ALW, 2'd0);
          3'd5: rec = mk_rec(CL_DEC8, reg8_sel(fy), OP_NONE, CC_ALW, 2'd0);
          3'd6: rec = mk_rec(CL_LD8,  reg8_sel(fy), OP_IMM8, CC_ALW, 2'd1);
          default: rec = mk_rec(dec_class_e'(5'd10 + {2'b00, fy}),
                                OP_NONE, OP_NONE, CC_ALW, 2'd0);
        endcase
      end
      2'd1: begin
        // the mem-HL to mem-HL slot is the halt opcode
        if (fy == 3'd6 && fz == 3'd6)
          rec = mk_rec(CL_HALT, OP_NONE, OP_NONE, CC_ALW, 2'd0);
        else
          rec = mk_rec(CL_LD8, reg8_sel(fy), reg8_sel(fz), CC_ALW, 2'd0);
      end
      2'd2: rec = mk_rec(dec_class_e'(5'd19 + {2'b00, fy}),
                         OP_A, reg8_sel(fz), CC_ALW, 2'd0);
      default: begin
        if (fz == 3'd0) begin
          case (fy)
            3'd0, 3'd1, 3'd2, 3'd3:
              rec = mk_rec(CL_RET, OP_NONE, OP_NONE, cond_e'({1'b0, fy[1:0]}), 2'd0);
            3'd4: rec = mk_rec(CL_LD8,   OP_MHIGH8, OP_A,     CC_ALW, 2'd1);
            3'd5: rec = mk_rec(CL_ADDSP, OP_SP,     OP_SIMM8, CC_ALW, 2'd1);
            default: rec = ILLEGAL_REC;
          endcase
        end
      end
    endcase
  end
endmodule

// File: rtl/opdec8_prefix_trk.sv
module opdec8_prefix_trk #(
  parameter int             OPW         = 8,
  parameter logic [OPW-1:0] PREFIX_CODE = 8'hCB
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_byte,
  output logic           take_prefixed,
  output logic           swallow
);
  logic pend;

  assign take_prefixed = op_valid && pend;
  assign swallow       = op_valid && !pend && (op_byte == PREFIX_CODE);

  always_ff @(posedge clk) begin
    if (rst)                pend <= 1'b0;
    else if (take_prefixed) pend <= 1'b0;
    else if (swallow)       pend <= 1'b1;
  end

  p_prefix_arms_r12: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !pend && op_byte == PREFIX_CODE) |=> pend);

  p_prefix_drops_r12: assert property (@(posedge clk) disable iff (rst)
    (op_valid && pend) |=> !pend);
endmodule

// File: rtl/opdec8_core.sv
module opdec8_core
  import opdec8_pkg::*;
#(
  parameter int             OPW         = 8,
  parameter logic [OPW-1:0] PREFIX_CODE = 8'hCB
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_byte,
  output logic           dec_done,
  output logic [4:0]     dec_class,
  output logic [4:0]     dec_dst,
  output logic [4:0]     dec_src,
  output logic [2:0]     dec_cond,
  output logic [1:0]     dec_imm_len,
  output logic           dec_prefixed,
  output logic           dec_illegal,
  output logic [OPW-1:0] dec_raw
);
  logic [1:0] fx;
  logic [2:0] fy;
  logic [2:0] fz;
  logic [1:0] fp;
  logic       fq;
  dec_rec_t   main_rec;
  dec_rec_t   next_rec;
  logic       take_prefixed;
  logic       swallow;

  opdec8_fields #(.OPW(OPW)) u_fields (
    .op (op_byte), .fx (fx), .fy (fy), .fz (fz), .fp (fp), .fq (fq)
  );

  opdec8_main_table u_table (
    .fx (fx), .fy (fy), .fz (fz), .fp (fp), .fq (fq), .rec (main_rec)
  );

  opdec8_prefix_trk #(.OPW(OPW), .PREFIX_CODE(PREFIX_CODE)) u_prefix (
    .clk           (clk),
    .rst           (rst),
    .op_valid      (op_valid),
    .op_byte       (op_byte),
    .take_prefixed (take_prefixed),
    .swallow       (swallow)
  );

  always_comb begin
    if (take_prefixed)
      next_rec = mk_rec(CL_PREFIXED, OP_NONE, OP_NONE, CC_ALW, 2'd0);
    else
      next_rec = main_rec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_done     <= 1'b0;
      dec_class    <= '0;
      dec_dst      <= '0;
      dec_src      <= '0;
      dec_cond     <= '0;
      dec_imm_len  <= '0;
      dec_prefixed <= 1'b0;
      dec_illegal  <= 1'b0;
      dec_raw      <= '0;
    end else begin
      dec_done <= op_valid && !swallow;
      if (op_valid && !swallow) begin
        dec_class    <= next_rec.cls;
        dec_dst      <= next_rec.dst;
        dec_src      <= next_rec.src;
        dec_cond     <= next_rec.cc;
        dec_imm_len  <= next_rec.imm;
        dec_prefixed <= take_prefixed;
        dec_illegal  <= next_rec.ill;
        dec_raw      <= op_byte;
      end
    end
  end

  p_done_after_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    dec_done |-> $past(op_valid));

  p_illegal_clean_r13: assert property (@(posedge clk) disable iff (rst)
    (dec_done && dec_illegal) |-> (dec_class == CL_ILLEGAL && dec_imm_len == 2'd0));

  p_halt_only_76_r8: assert property (@(posedge clk) disable iff (rst)
    (dec_done && dec_class == CL_HALT) |-> (dec_raw == 8'h76 && !dec_prefixed));

  p_imm_range_r11: assert property (@(posedge clk) disable iff (rst)
    dec_done |-> (dec_imm_len != 2'd3));

  p_prefixed_legal_r12: assert property (@(posedge clk) disable iff (rst)
    (dec_done && dec_prefixed) |-> (!dec_illegal && dec_class == CL_PREFIXED));
endmodule

// File: tb/tb_opdec8_core.sv
module tb_opdec8_core;
  import opdec8_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [7:0] op_byte = 8'h00;
  logic       dec_done;
  logic [4:0] dec_class, dec_dst, dec_src;
  logic [2:0] dec_cond;
  logic [1:0] dec_imm_len;
  logic       dec_prefixed, dec_illegal;
  logic [7:0] dec_raw;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  opdec8_core dut (
    .clk (clk), .rst (rst), .op_valid (op_valid), .op_byte (op_byte),
    .dec_done (dec_done), .dec_class (dec_class), .dec_dst (dec_dst),
    .dec_src (dec_src), .dec_cond (dec_cond), .dec_imm_len (dec_imm_len),
    .dec_prefixed (dec_prefixed), .dec_illegal (dec_illegal), .dec_raw (dec_raw)
  );

  // vector: {byte, class, dst, src, cond, imm, illegal}
  localparam int NV = 56;
  localparam logic [28:0] VEC [NV] = '{
    {8'h00, CL_NOP,   OP_NONE, OP_NONE,  CC_ALW, 2'd0, 1'b0},
    {8'h08, CL_LD16,  OP_MA16, OP_SP,    CC_ALW, 2'd2, 1'b0},
    {8'h10, CL_STOP,  OP_NONE, OP_NONE,  CC_ALW, 2'd0, 1'b0},
    {8'h18, CL_JR,    OP_NONE, OP_SIMM8, CC_ALW, 2'd1, 1'b0},
    {8'h20, CL_JR,    OP_NONE, OP_SIMM8, CC_NZ,  2'd1, 1'b0},
    {8'h28, CL_JR,    OP_NONE, OP_SIMM8, CC_Z,   2'd1, 1'b0},
    {8'h30, CL_JR,    OP_NONE, OP_SIMM8, CC_NC,  2'd1, 1'b0},
    {8'h38, CL_JR,    OP_NONE, OP_SIMM8, CC_C,   2'd1, 1'b0},
    {8'h01, CL_LD16,  OP_BC,   OP_IMM16, CC_ALW, 2'd2, 1'b0},
    {8'h21, CL_LD16,  OP_HL,   OP_IMM16, CC_ALW, 2'd2, 1'b0},
    {8'h31, CL_LD16,  OP_SP,   OP_IMM16, CC_ALW, 2'd2, 1'b0},
    {8'h09, CL_ADD16, OP_HL,   OP_BC,    CC_ALW, 2'd0, 1'b0},
    {8'h39, CL_ADD16, OP_HL,   OP_SP,    CC_ALW, 2'd0, 1'b0},
    {8'h02, CL_LD8,   OP_MBC,  OP_A,     CC_ALW, 2'd0, 1'b0},
    {8'h0A, CL_LD8,   OP_A,    OP_MBC,   CC_ALW, 2'd0, 1'b0},
    {8'h12, CL_LD8,   OP_MDE,  OP_A,     CC_ALW, 2'd0, 1'b0},
    {8'h1A, CL_LD8,   OP_A,    OP_MDE,   CC_ALW, 2'd0, 1'b0},
    {8'h22, CL_LD8,   OP_MHLI, OP_A,     CC_ALW, 2'd0, 1'b0},
    {8'h2A, CL_LD8,   OP_A,    OP_MHLI,  CC_ALW, 2'd0, 1'b0},
    {8'h32, CL_LD8,   OP_MHLD, OP_A,     CC_ALW, 2'd0, 1'b0},
    {8'h3A, CL_LD8,   OP_A,    OP_MHLD,  CC_ALW, 2'd0, 1'b0},
    {8'h03, CL_INC16, OP_BC,   OP_NONE,  CC_ALW, 2'd0, 1'b0},
    {8'h1B, CL_DEC16, OP_DE,   OP_NONE,  CC_ALW, 2'd0, 1'b0},
    {8'h04, CL_INC8,  OP_B,    OP_NONE,  CC_ALW, 2'd0, 1'b0},
    {8'h3C, CL_INC8,  OP_A,    OP_NONE,  CC_ALW, 2'd0, 1'b0},
    {8'h35, CL_DEC8,  OP_MHL,  OP_NONE,  CC_ALW, 2'd0, 1'b0},
    {8'h06, CL_LD8,   OP_B,    OP_IMM8,  CC_ALW, 2'd1, 1'b0},
    {8'h3E, CL_LD8,   OP_A,    OP_IMM8,  CC_ALW, 2'd1, 1'b0},
    {8'h07, CL_RLCA,  OP_NONE, OP_NONE,  CC_ALW, 2'd0, 1'b0},
    {8'h1F, CL_RRA,   OP_NONE, OP_NONE,  CC_ALW, 2'd0, 1'b0},
    {8'h27, CL_DAA,   OP_NONE, OP_NONE,  CC_ALW, 2'd0, 1'b0},
    {8'h3F, CL_CCF,   OP_NONE, OP_NONE,  CC_ALW, 2'd0, 1'b0},
    {8'h76, CL_HALT,  OP_NONE, OP_NONE,  CC_ALW, 2'd0, 1'b0},
    {8'h77, CL_LD8,   OP_MHL,  OP_A,     CC_ALW, 2'd0, 1'b0},
    {8'h6E, CL_LD8,   OP_L,    OP_MHL,   CC_ALW, 2'd0, 1'b0},
    {8'h40, CL_LD8,   OP_B,    OP_B,     CC_ALW, 2'd0, 1'b0},
    {8'h7E, CL_LD8,   OP_A,    OP_MHL,   CC_ALW, 2'd0, 1'b0},
    {8'h80, CL_ADD,   OP_A,    OP_B,     CC_ALW, 2'd0, 1'b0},
    {8'h8E, CL_ADC,   OP_A,    OP_MHL,   CC_ALW, 2'd0, 1'b0},
    {8'h97, CL_SUB,   OP_A,    OP_A,     CC_ALW, 2'd0, 1'b0},
    {8'h99, CL_SBC,   OP_A,    OP_C,     CC_ALW, 2'd0, 1'b0},
    {8'hA2, CL_AND,   OP_A,    OP_D,     CC_ALW, 2'd0, 1'b0},
    {8'hAB, CL_XOR,   OP_A,    OP_E,     CC_ALW, 2'd0, 1'b0},
    {8'hB4, CL_OR,    OP_A,    OP_H,     CC_ALW, 2'd0, 1'b0},
    {8'hBD, CL_CP,    OP_A,    OP_L,     CC_ALW, 2'd0, 1'b0},
    {8'hC0, CL_RET,   OP_NONE, OP_NONE,  CC_NZ,  2'd0, 1'b0},
    {8'hC8, CL_RET,   OP_NONE, OP_NONE,  CC_Z,   2'd0, 1'b0},
    {8'hD0, CL_RET,   OP_NONE, OP_NONE,  CC_NC,  2'd0, 1'b0},
    {8'hD8, CL_RET,   OP_NONE, OP_NONE,  CC_C,   2'd0, 1'b0},
    {8'hE0, CL_LD8,   OP_MHIGH8, OP_A,   CC_ALW, 2'd1, 1'b0},
    {8'hE8, CL_ADDSP, OP_SP,   OP_SIMM8, CC_ALW, 2'd1, 1'b0},
    {8'hF0, CL_ILLEGAL, OP_NONE, OP_NONE, CC_ALW, 2'd0, 1'b1},
    {8'hF8, CL_ILLEGAL, OP_NONE, OP_NONE, CC_ALW, 2'd0, 1'b1},
    {8'hC3, CL_ILLEGAL, OP_NONE, OP_NONE, CC_ALW, 2'd0, 1'b1},
    {8'hFF, CL_ILLEGAL, OP_NONE, OP_NONE, CC_ALW, 2'd0, 1'b1},
    {8'hD9, CL_ILLEGAL, OP_NONE, OP_NONE, CC_ALW, 2'd0, 1'b1}
  };

  localparam logic [20:0] PFX_REC = {CL_PREFIXED, OP_NONE, OP_NONE, CC_ALW, 2'd0, 1'b0};

  function automatic logic [20:0] got_rec();
    return {dec_class, dec_dst, dec_src, dec_cond, dec_imm_len, dec_illegal};
  endfunction

  function automatic string tag_of(input logic [7:0] b);
    if (b[7:6] == 2'd0) begin
      case (b[2:0])
        3'd0:       return "R3";
        3'd1, 3'd3: return "R5";
        3'd2:       return "R6";
        default:    return "R7";
      endcase
    end
    if (b[7:6] == 2'd1) return "R8";
    if (b[7:6] == 2'd2) return "R9";
    if (b[2:0] == 3'd0 && b[5:3] < 3'd6) return "R10";
    return "R13";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    op_valid = 1'b1;
    op_byte  = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    op_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    check("R1 reset outputs", {dec_done, dec_prefixed, dec_raw, got_rec()}, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][28:21]);
      check({tag_of(VEC[i][28:21]), " decode"},
            {dec_done, dec_prefixed, dec_raw, got_rec()},
            {1'b1, 1'b0, VEC[i][28:21], VEC[i][20:0]});
      check("R11 imm length", {30'd0, dec_imm_len}, {30'd0, VEC[i][2:1]});
      if (VEC[i][5:3] != 3'(CC_ALW))
        check("R4 condition", {29'd0, dec_cond}, {29'd0, VEC[i][5:3]});
    end

    // R2: pulse lasts one cycle, record held
    @(negedge clk);
    check("R2 done single pulse", {31'd0, dec_done}, 32'd0);
    check("R2 record held", {11'd0, got_rec()}, {11'd0, VEC[NV-1][20:0]});

    // R2: consecutive strobes
    @(negedge clk);
    op_valid = 1'b1; op_byte = 8'h3C;
    @(negedge clk);
    op_byte = 8'h80;
    check("R2 back-to-back first", {dec_done, dec_raw, 18'd0, dec_class},
          {1'b1, 8'h3C, 18'd0, CL_INC8});
    @(negedge clk);
    op_valid = 1'b0;
    check("R2 back-to-back second", {dec_done, dec_raw, 18'd0, dec_class},
          {1'b1, 8'h80, 18'd0, CL_ADD});

    // R12: prefix swallowed then next byte prefixed
    send(8'hCB);
    check("R12 prefix swallowed", {31'd0, dec_done}, 32'd0);
    send(8'h37);
    check("R12 prefixed byte", {dec_done, dec_prefixed, dec_raw, got_rec()},
          {1'b1, 1'b1, 8'h37, PFX_REC});
    send(8'h00);
    check("R12 prefix cleared", {dec_done, dec_prefixed, dec_raw, got_rec()},
          {1'b1, 1'b0, 8'h00, VEC[0][20:0]});

    // R12: idle gap after prefix
    send(8'hCB);
    repeat (3) @(negedge clk);
    check("R12 no result during gap", {31'd0, dec_done}, 32'd0);
    send(8'h11);
    check("R12 prefixed after gap", {dec_done, dec_prefixed, dec_raw, got_rec()},
          {1'b1, 1'b1, 8'h11, PFX_REC});

    // R12: prefix twice
    send(8'hCB);
    send(8'hCB);
    check("R12 double prefix", {dec_done, dec_prefixed, dec_raw, got_rec()},
          {1'b1, 1'b1, 8'hCB, PFX_REC});
    send(8'hCB);
    check("R12 third prefix swallowed", {31'd0, dec_done}, 32'd0);
    send(8'h76);
    check("R12 halt value prefixed", {dec_prefixed, 26'd0, dec_class},
          {1'b1, 26'd0, CL_PREFIXED});

    // R1: reset drops pending prefix
    send(8'hCB);
    do_reset();
    check("R1 reset clears outputs", {dec_done, dec_prefixed, dec_raw, got_rec()}, 32'd0);
    send(8'h00);
    check("R1 prefix dropped by reset", {dec_done, dec_prefixed, dec_illegal, 24'd0, dec_class},
          {1'b1, 1'b0, 1'b0, 24'd0, CL_NOP});

    // R13: illegal after prefix cleared is still illegal, not NOP
    send(8'hFC);
    check("R13 illegal flag", {dec_illegal, 26'd0, dec_class}, {1'b1, 26'd0, CL_ILLEGAL});

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule